// File: doc/BRIEF.md
# Scalar Register-Lane Bundle Executor

This block accepts 64-byte instruction bundles, one per cycle, through a valid/ready handshake on a 512-bit input word. It decodes two bundle kinds, a scalar register move and a scalar ALU operation, and executes them against a 64-entry file of 32-bit registers. A 64-bit operation reads and writes two consecutive entries. Operands come from registers or from an immediate carried inside the bundle, as selected by a mode byte.

Each accepted bundle is executed in the cycle it is accepted. One cycle later the block raises a one-cycle completion pulse, together with an error flag and an error code. Encodings that are unknown, malformed or unsupported leave the register file untouched. Divide and remainder by zero are the exception: they still write a result and report their own error code. A combinational read port lets the consuming logic observe any register.

Top module: `scl_bundle_exec`

## Requirements
- R1: `bnd_ready` rises on the second clock edge after reset is released and then stays high. Every accepted bundle produces `xd_done` high for exactly one cycle, on the cycle after the accepting edge. `xd_err` and `xd_code` are valid in that same cycle.
- R2: Reset clears all 64 registers to zero. `rf_val` always shows the register selected by `rf_idx`, with no added latency.
- R3: Byte k of a bundle occupies `bnd_data[8k+7:8k]`. Byte 0 selects the kind: 0xA7 is a move and 0xA8 is an ALU operation. Any other value gives code 1 and no write. Codes are 0 none, 1 opcode, 2 format, 3 unsupported op, 4 divide by zero.
- R4: For a move, byte 0x0C set to 1 selects a 32-bit move. Byte 0x0E selects the source: 0 takes the register whose id is in byte 0x10, and 1 takes the little-endian dword at bytes 0x20–0x23. The destination id is in byte 0x18.
- R5: A move with byte 0x0C set to 2 is 64 bits wide and writes the qword at bytes 0x20–0x27. Its low half goes to the register in byte 0x18 and its high half to the register in byte 0x19, which must equal the low id plus 1. A 64-bit move with a register source (byte 0x0E = 0) is illegal and gives code 2.
- R6: The following give code 2 and write nothing: a count byte other than 1 or 2, a mode byte above 1, any register id that is used and is 64 or more, and a 64-bit pair that is not consecutive.
- R7: ALU op byte 0x0C uses this code map. 00 pass src1, 01 not, 02 shift left, 03 arithmetic shift right, 04 add, 05 subtract, 06 multiply, 07 divide, 08 max, 09 min. 0A/0B/0C are bitwise and/or/xor. 0D/0E/0F are logical and/or/xor. 10/11 are logical shift left/right. 12 is equal, 13 greater, 14 greater-or-equal, 15 less-or-equal, 16 less, 18 not-equal, 19 abs and 1B mod. Compares write 1 or 0.
- R8: A 32-bit ALU operation (byte 0x0D = 1) reads src1 from the register in byte 0x11. Its second operand is the register in byte 0x12 when byte 0x0E is 0, or the dword at byte 0x18 when it is 1. The result goes to the register in byte 0x10.
- R9: A 64-bit ALU operation (byte 0x0D = 2) reads each register operand from the pair (id, id+1), low word first, or takes the qword at byte 0x18 as the immediate. It writes the low result word to the register in byte 0x14 and the high word to the register in byte 0x15.
- R10: Op codes 0x1A (pow) and 0x1D (rsqrt), and every code not listed in R7, give code 3 and no write.
- R11: Divide and mod are unsigned. With a zero divisor they write all ones at the operation width and give code 4.
- R12: Shift amounts are taken modulo the operation width, and arithmetic right shift fills with the sign bit. Compares, max, min and abs treat the operands as signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_valid | input | 1 | Bundle present |
| bnd_ready | output | 1 | Block can take a bundle |
| bnd_data | input | 512 | Bundle bytes, byte 0 in the low bits |
| xd_done | output | 1 | One-cycle completion pulse |
| xd_err | output | 1 | Completed bundle raised an error |
| xd_code | output | 3 | Error code of the completed bundle |
| rf_idx | input | 6 | Register to observe |
| rf_val | output | 32 | Contents of the observed register |

## Verification
The assertions assume that `bnd_valid` is only meaningful while reset is low, and that bundle bytes outside the defined fields carry no meaning. The bench raises valid for exactly one cycle per bundle, built from zeroed words with only the named bytes set. It never combines a format fault with an unsupported op code, so the order in which faults are ranked is never exercised. Register contents are observed only between bundles, through the read port.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int BUNDLE_W = 512;
    localparam int NBYTES   = BUNDLE_W / 8;
    localparam int RF_DEPTH = 64;
    localparam int RF_AW    = $clog2(RF_DEPTH);
    localparam int WORD_W   = 32;
    localparam int DWORD_W  = 2 * WORD_W;

    localparam logic [7:0] OPC_MOVE = 8'hA7;
    localparam logic [7:0] OPC_ALU  = 8'hA8;

    // byte positions of move fields
    localparam int MV_CNT  = 'h0C;
    localparam int MV_MODE = 'h0E;
    localparam int MV_SRC  = 'h10;
    localparam int MV_DLO  = 'h18;
    localparam int MV_DHI  = 'h19;
    localparam int MV_IMM  = 'h20;

    // byte positions of ALU fields
    localparam int AL_OP   = 'h0C;
    localparam int AL_CNT  = 'h0D;
    localparam int AL_MODE = 'h0E;
    localparam int AL_DST  = 'h10;
    localparam int AL_S1   = 'h11;
    localparam int AL_S2   = 'h12;
    localparam int AL_PLO  = 'h14;
    localparam int AL_PHI  = 'h15;
    localparam int AL_IMM  = 'h18;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_OPCODE  = 3'd1,
        ERR_FORMAT  = 3'd2,
        ERR_UNSUP   = 3'd3,
        ERR_DIVZERO = 3'd4
    } err_e;

    typedef enum logic [4:0] {
        FN_PASS, FN_NOT, FN_ASL, FN_ASR, FN_ADD, FN_SUB, FN_MUL, FN_DIV,
        FN_MAX, FN_MIN, FN_AND, FN_OR, FN_XOR, FN_LAND, FN_LOR, FN_LXOR,
        FN_LSL, FN_LSR, FN_EQ, FN_NE, FN_GT, FN_GE, FN_LT, FN_LE,
        FN_ABS, FN_MOD, FN_BAD
    } alu_fn_e;

    typedef struct packed {
        logic               wide;
        logic               imm_a;
        logic               imm_b;
        logic [RF_AW-1:0]   rs_a;
        logic [RF_AW-1:0]   rs_b;
        logic [RF_AW-1:0]   rd_lo;
        logic [RF_AW-1:0]   rd_hi;
        alu_fn_e            fn;
        logic [DWORD_W-1:0] imm;
        err_e               err;
    } dec_t;

    // wire op byte -> internal function; compares and tail are permuted
    function automatic alu_fn_e wire_to_fn(input logic [7:0] w);
        case (w)
            8'h00: return FN_PASS;
            8'h01: return FN_NOT;
            8'h02: return FN_ASL;
            8'h03: return FN_ASR;
            8'h04: return FN_ADD;
            8'h05: return FN_SUB;
            8'h06: return FN_MUL;
            8'h07: return FN_DIV;
            8'h08: return FN_MAX;
            8'h09: return FN_MIN;
            8'h0A: return FN_AND;
            8'h0B: return FN_OR;
            8'h0C: return FN_XOR;
            8'h0D: return FN_LAND;
            8'h0E: return FN_LOR;
            8'h0F: return FN_LXOR;
            8'h10: return FN_LSL;
            8'h11: return FN_LSR;
            8'h12: return FN_EQ;
            8'h13: return FN_GT;
            8'h14: return FN_GE;
            8'h15: return FN_LE;
            8'h16: return FN_LT;
            8'h18: return FN_NE;
            8'h19: return FN_ABS;
            8'h1B: return FN_MOD;
            default: return FN_BAD;  // includes pow 0x1A and rsqrt 0x1D
        endcase
    endfunction

    function automatic logic [DWORD_W-1:0] imm_at(input logic [BUNDLE_W-1:0] b,
                                                   input int pos, input logic wide);
        logic [DWORD_W-1:0] q;
        q = b[pos*8 +: DWORD_W];
        return wide ? q : {{WORD_W{1'b0}}, q[WORD_W-1:0]};
    endfunction

    // a register id used alone, or as the low half of a pair
    function automatic logic id_bad(input logic [7:0] id, input logic wide);
        return wide ? ({1'b0, id} >= 9'(RF_DEPTH - 1)) : ({1'b0, id} >= 9'(RF_DEPTH));
    endfunction

    function automatic logic pair_bad(input logic [7:0] lo, input logic [7:0] hi);
        return id_bad(lo, 1'b1) || (hi != lo + 8'd1);
    endfunction

endpackage

// File: rtl/scl_decode.sv
module scl_decode
    import scl_pkg::*;
(
    input  logic [BUNDLE_W-1:0] bundle,
    output dec_t                dec
);
    logic [NBYTES-1:0][7:0] by;
    assign by = bundle;

    logic [7:0] cnt;
    logic [7:0] mode;
    logic       fmt_bad;

    always_comb begin
        dec       = '0;
        dec.fn    = FN_PASS;
        dec.err   = ERR_NONE;
        cnt       = 8'd0;
        mode      = 8'd0;
        fmt_bad   = 1'b0;
        if (by[0] == OPC_MOVE) begin
            cnt        = by[MV_CNT];
            mode       = by[MV_MODE];
            dec.wide   = (cnt == 8'd2);
            dec.imm_a  = mode[0];
            dec.rs_a   = by[MV_SRC][RF_AW-1:0];
            dec.rd_lo  = by[MV_DLO][RF_AW-1:0];
            dec.rd_hi  = by[MV_DHI][RF_AW-1:0];
            dec.imm    = imm_at(bundle, MV_IMM, dec.wide);
            fmt_bad    = (cnt != 8'd1 && cnt != 8'd2) || (mode > 8'd1)
                       || (dec.wide && mode == 8'd0)
                       || (dec.wide ? pair_bad(by[MV_DLO], by[MV_DHI]) : id_bad(by[MV_DLO], 1'b0))
                       || (mode == 8'd0 && id_bad(by[MV_SRC], 1'b0));
            dec.err    = fmt_bad ? ERR_FORMAT : ERR_NONE;
        end else if (by[0] == OPC_ALU) begin
            cnt        = by[AL_CNT];
            mode       = by[AL_MODE];
            dec.wide   = (cnt == 8'd2);
            dec.imm_b  = mode[0];
            dec.fn     = wire_to_fn(by[AL_OP]);
            dec.rs_a   = by[AL_S1][RF_AW-1:0];
            dec.rs_b   = by[AL_S2][RF_AW-1:0];
            dec.rd_lo  = dec.wide ? by[AL_PLO][RF_AW-1:0] : by[AL_DST][RF_AW-1:0];
            dec.rd_hi  = by[AL_PHI][RF_AW-1:0];
            dec.imm    = imm_at(bundle, AL_IMM, dec.wide);
            fmt_bad    = (cnt != 8'd1 && cnt != 8'd2) || (mode > 8'd1)
                       || (dec.wide ? pair_bad(by[AL_PLO], by[AL_PHI]) : id_bad(by[AL_DST], 1'b0))
                       || id_bad(by[AL_S1], dec.wide)
                       || (mode == 8'd0 && id_bad(by[AL_S2], dec.wide));
            if (fmt_bad)
                dec.err = ERR_FORMAT;
            else if (dec.fn == FN_BAD)
                dec.err = ERR_UNSUP;
        end else begin
            dec.err = ERR_OPCODE;
        end
    end
endmodule

// File: rtl/scl_alu.sv
module scl_alu
    import scl_pkg::*;
(
    input  alu_fn_e            fn,
    input  logic               wide,
    input  logic [DWORD_W-1:0] opa,
    input  logic [DWORD_W-1:0] opb,
    output logic [DWORD_W-1:0] res,
    output logic               div0
);
    logic [DWORD_W-1:0] au, bu, as, bs, r;
    logic [5:0]         sh;
    logic               za, zb;

    always_comb begin
        au   = wide ? opa : {{WORD_W{1'b0}}, opa[WORD_W-1:0]};
        bu   = wide ? opb : {{WORD_W{1'b0}}, opb[WORD_W-1:0]};
        as   = wide ? opa : {{WORD_W{opa[WORD_W-1]}}, opa[WORD_W-1:0]};
        bs   = wide ? opb : {{WORD_W{opb[WORD_W-1]}}, opb[WORD_W-1:0]};
        sh   = wide ? opb[5:0] : {1'b0, opb[4:0]};
        za   = (au != '0);
        zb   = (bu != '0);
        div0 = (fn == FN_DIV || fn == FN_MOD) && (bu == '0);
        case (fn)
            FN_PASS: r = au;
            FN_NOT:  r = ~au;
            FN_ASL:  r = au << sh;
            FN_ASR:  r = DWORD_W'($signed(as) >>> sh);
            FN_ADD:  r = au + bu;
            FN_SUB:  r = au - bu;
            FN_MUL:  r = au * bu;
            FN_DIV:  r = div0 ? '1 : au / bu;
            FN_MOD:  r = div0 ? '1 : au % bu;
            FN_MAX:  r = ($signed(as) > $signed(bs)) ? as : bs;
            FN_MIN:  r = ($signed(as) < $signed(bs)) ? as : bs;
            FN_AND:  r = au & bu;
            FN_OR:   r = au | bu;
            FN_XOR:  r = au ^ bu;
            FN_LAND: r = DWORD_W'(za && zb);
            FN_LOR:  r = DWORD_W'(za || zb);
            FN_LXOR: r = DWORD_W'(za ^ zb);
            FN_LSL:  r = au << sh;
            FN_LSR:  r = au >> sh;
            FN_EQ:   r = DWORD_W'(as == bs);
            FN_NE:   r = DWORD_W'(as != bs);
            FN_GT:   r = DWORD_W'($signed(as) > $signed(bs));
            FN_GE:   r = DWORD_W'($signed(as) >= $signed(bs));
            FN_LT:   r = DWORD_W'($signed(as) < $signed(bs));
            FN_LE:   r = DWORD_W'($signed(as) <= $signed(bs));
            FN_ABS:  r = as[DWORD_W-1] ? (~as + 1'b1) : as;
            default: r = '0;
        endcase
        res = wide ? r : {{WORD_W{1'b0}}, r[WORD_W-1:0]};
    end
endmodule

// File: rtl/scl_regfile.sv
module scl_regfile
    import scl_pkg::*;
#(
    parameter int NRD = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we_lo,
    input  logic [RF_AW-1:0]            wa_lo,
    input  logic [WORD_W-1:0]           wd_lo,
    input  logic                        we_hi,
    input  logic [RF_AW-1:0]            wa_hi,
    input  logic [WORD_W-1:0]           wd_hi,
    input  logic [NRD-1:0][RF_AW-1:0]   ra,
    output logic [NRD-1:0][WORD_W-1:0]  rd
);
    logic [WORD_W-1:0] mem [RF_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RF_DEPTH; i++) mem[i] <= '0;
        end else begin
            if (we_lo) mem[wa_lo] <= wd_lo;
            if (we_hi) mem[wa_hi] <= wd_hi;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd[p] = mem[ra[p]];
    end
endmodule

// File: rtl/scl_bundle_exec.sv
module scl_bundle_exec
    import scl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bnd_valid,
    output logic                 bnd_ready,
    input  logic [BUNDLE_W-1:0]  bnd_data,
    output logic                 xd_done,
    output logic                 xd_err,
    output logic [2:0]           xd_code,
    input  logic [RF_AW-1:0]     rf_idx,
    output logic [WORD_W-1:0]    rf_val
);
    localparam int NRD = 5;

    dec_t                        dec;
    logic                        accept;
    logic [NRD-1:0][RF_AW-1:0]   ra;
    logic [NRD-1:0][WORD_W-1:0]  rd;
    logic [DWORD_W-1:0]          reg_a, reg_b, opa, opb, res;
    logic                        div0;
    err_e                        err_now, code_q;
    logic                        rdy_q, done_q, err_q;
    logic                        wr_lo_en, wr_hi_en;

    scl_decode u_dec (.bundle(bnd_data), .dec(dec));

    assign ra[0] = dec.rs_a;
    assign ra[1] = dec.rs_a + 1'b1;
    assign ra[2] = dec.rs_b;
    assign ra[3] = dec.rs_b + 1'b1;
    assign ra[4] = rf_idx;

    assign reg_a = {rd[1], rd[0]};
    assign reg_b = {rd[3], rd[2]};
    assign opa   = dec.imm_a ? dec.imm : reg_a;
    assign opb   = dec.imm_b ? dec.imm : reg_b;

    scl_alu u_alu (.fn(dec.fn), .wide(dec.wide), .opa(opa), .opb(opb), .res(res), .div0(div0));

    assign accept   = bnd_valid && rdy_q;
    assign err_now  = (dec.err != ERR_NONE) ? dec.err : (div0 ? ERR_DIVZERO : ERR_NONE);
    assign wr_lo_en = accept && (dec.err == ERR_NONE);
    assign wr_hi_en = wr_lo_en && dec.wide;

    scl_regfile #(.NRD(NRD)) u_rf (
        .clk(clk), .rst(rst),
        .we_lo(wr_lo_en), .wa_lo(dec.rd_lo), .wd_lo(res[WORD_W-1:0]),
        .we_hi(wr_hi_en), .wa_hi(dec.rd_hi), .wd_hi(res[DWORD_W-1:WORD_W]),
        .ra(ra), .rd(rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
        end else begin
            rdy_q  <= 1'b1;
            done_q <= accept;
            err_q  <= accept && (err_now != ERR_NONE);
            code_q <= accept ? err_now : ERR_NONE;
        end
    end

    assign bnd_ready = rdy_q;
    assign xd_done   = done_q;
    assign xd_err    = err_q;
    assign xd_code   = code_q;
    assign rf_val    = rd[4];
endmodule

// File: rtl/scl_bundle_exec_chk.sv
module scl_bundle_exec_chk
    import scl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bnd_valid,
    input logic             bnd_ready,
    input logic             xd_done,
    input logic             xd_err,
    input logic [2:0]       xd_code,
    input logic             we_lo,
    input logic             we_hi,
    input logic [RF_AW-1:0] wa_lo,
    input logic [RF_AW-1:0] wa_hi
);
    AST_READY_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
        bnd_ready |=> bnd_ready);                                            // R1
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        xd_done |-> $past(bnd_valid && bnd_ready));                          // R1
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        xd_err |-> xd_done);                                                 // R1
    AST_CODE_AGREES_FLAG: assert property (@(posedge clk) disable iff (rst)
        xd_done |-> ((xd_code != 3'd0) == xd_err));                          // R3
    AST_WRITE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (we_lo || we_hi) |-> (bnd_valid && bnd_ready));                      // R6
    AST_PAIR_CONSECUTIVE: assert property (@(posedge clk) disable iff (rst)
        we_hi |-> (we_lo && wa_hi == RF_AW'(wa_lo + 1'b1)));                 // R5
    AST_WRITE_ONLY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        we_lo |=> (!xd_err || xd_code == 3'd4));                             // R10
endmodule

bind scl_bundle_exec scl_bundle_exec_chk chk_i (
    .clk(clk), .rst(rst), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
    .xd_done(xd_done), .xd_err(xd_err), .xd_code(xd_code),
    .we_lo(wr_lo_en), .we_hi(wr_hi_en), .wa_lo(dec.rd_lo), .wa_hi(dec.rd_hi)
);

// File: tb/scl_bundle_exec_tb_top.sv
module scl_bundle_exec_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bnd_valid = 1'b0;
    logic         bnd_ready;
    logic [511:0] bnd_data = '0;
    logic         xd_done, xd_err;
    logic [2:0]   xd_code;
    logic [5:0]   rf_idx = '0;
    logic [31:0]  rf_val;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    scl_bundle_exec dut_i (
        .clk(clk), .rst(rst), .bnd_valid(bnd_valid), .bnd_ready(bnd_ready),
        .bnd_data(bnd_data), .xd_done(xd_done), .xd_err(xd_err), .xd_code(xd_code),
        .rf_idx(rf_idx), .rf_val(rf_val)
    );

    task automatic chk_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] mk_mv(input int cnt, input int mode, input int src,
                                           input int dlo, input int dhi, input logic [63:0] imm);
        logic [511:0] b = '0;
        b[0 +: 8]      = 8'hA7;
        b['h0C*8 +: 8] = 8'(cnt);
        b['h0E*8 +: 8] = 8'(mode);
        b['h10*8 +: 8] = 8'(src);
        b['h18*8 +: 8] = 8'(dlo);
        b['h19*8 +: 8] = 8'(dhi);
        b['h20*8 +: 64] = imm;
        return b;
    endfunction

    function automatic logic [511:0] mk_alu(input logic [7:0] op, input int cnt, input int mode,
                                            input int dst, input int s1, input int s2,
                                            input int plo, input int phi, input logic [63:0] imm);
        logic [511:0] b = '0;
        b[0 +: 8]      = 8'hA8;
        b['h0C*8 +: 8] = op;
        b['h0D*8 +: 8] = 8'(cnt);
        b['h0E*8 +: 8] = 8'(mode);
        b['h10*8 +: 8] = 8'(dst);
        b['h11*8 +: 8] = 8'(s1);
        b['h12*8 +: 8] = 8'(s2);
        b['h14*8 +: 8] = 8'(plo);
        b['h15*8 +: 8] = 8'(phi);
        b['h18*8 +: 64] = imm;
        return b;
    endfunction

    // drive one bundle for one cycle, then check the completion fields
    task automatic run(input string req, input logic [511:0] b, input int exp_code);
        @(negedge clk);
        bnd_data  = b;
        bnd_valid = 1'b1;
        @(negedge clk);
        bnd_valid = 1'b0;
        chk_eq(req, "done pulse", 64'(xd_done), 64'd1);
        chk_eq(req, "error code", 64'(xd_code), 64'(exp_code));
        chk_eq(req, "error flag", 64'(xd_err), 64'(exp_code != 0));
    endtask

    task automatic reg_is(input string req, input int idx, input logic [31:0] exp);
        rf_idx = 6'(idx);
        #1;
        chk_eq(req, $sformatf("r%0d", idx), 64'(rf_val), 64'(exp));
    endtask

    task automatic t_reset;
        chk_eq("R1", "ready after reset", 64'(bnd_ready), 64'd1);
        chk_eq("R1", "no done after reset", 64'(xd_done), 64'd0);
        reg_is("R2", 5, 32'd0);
        reg_is("R2", 63, 32'd0);
    endtask

    task automatic t_move32;
        run("R4", mk_mv(1, 1, 0, 3, 0, 64'hDEADBEEF), 0);
        reg_is("R4", 3, 32'hDEADBEEF);
        @(negedge clk);
        chk_eq("R1", "done lasts one cycle", 64'(xd_done), 64'd0);
        run("R4", mk_mv(1, 0, 3, 4, 0, 64'h0), 0);
        reg_is("R4", 4, 32'hDEADBEEF);
    endtask

    task automatic t_move64;
        run("R5", mk_mv(2, 1, 0, 10, 11, 64'h1122334455667788), 0);
        reg_is("R5", 10, 32'h55667788);
        reg_is("R5", 11, 32'h11223344);
        run("R5", mk_mv(2, 0, 3, 12, 13, 64'h0), 2);
        reg_is("R5", 12, 32'd0);
        run("R6", mk_mv(2, 1, 0, 14, 16, 64'h5), 2);
        reg_is("R6", 14, 32'd0);
        run("R6", mk_mv(3, 1, 0, 15, 0, 64'h5), 2);
        reg_is("R6", 15, 32'd0);
        run("R6", mk_mv(1, 1, 0, 70, 0, 64'h5), 2);
    endtask

    task automatic t_alu_basic;
        run("R4", mk_mv(1, 1, 0, 1, 0, 64'd5), 0);
        run("R4", mk_mv(1, 1, 0, 2, 0, 64'd7), 0);
        run("R8", mk_alu(8'h04, 1, 0, 20, 1, 2, 0, 0, 64'h0), 0);
        reg_is("R8", 20, 32'd12);
        run("R8", mk_alu(8'h05, 1, 1, 21, 1, 0, 0, 0, 64'd10), 0);
        reg_is("R8", 21, 32'hFFFFFFFB);
        run("R6", mk_alu(8'h04, 1, 2, 22, 1, 2, 0, 0, 64'h0), 2);
        reg_is("R6", 22, 32'd0);
    endtask

    task automatic t_compare;
        run("R7", mk_alu(8'h13, 1, 1, 22, 1, 0, 0, 0, 64'd7), 0);
        reg_is("R7", 22, 32'd0);   // 5 > 7
        run("R7", mk_alu(8'h14, 1, 1, 22, 1, 0, 0, 0, 64'd5), 0);
        reg_is("R7", 22, 32'd1);   // 5 >= 5
        run("R12", mk_alu(8'h16, 1, 0, 22, 21, 1, 0, 0, 64'h0), 0);
        reg_is("R12", 22, 32'd1);  // -5 < 5 signed
        run("R7", mk_alu(8'h15, 1, 1, 22, 1, 0, 0, 0, 64'd4), 0);
        reg_is("R7", 22, 32'd0);   // 5 <= 4
        run("R7", mk_alu(8'h18, 1, 0, 22, 1, 2, 0, 0, 64'h0), 0);
        reg_is("R7", 22, 32'd1);   // 5 != 7
        run("R7", mk_alu(8'h12, 1, 1, 22, 1, 0, 0, 0, 64'd5), 0);
        reg_is("R7", 22, 32'd1);   // 5 == 5
    endtask

    task automatic t_shift_misc;
        run("R4", mk_mv(1, 1, 0, 23, 0, 64'h80000000), 0);
        run("R12", mk_alu(8'h03, 1, 1, 22, 23, 0, 0, 0, 64'd4), 0);
        reg_is("R12", 22, 32'hF8000000);
        run("R7", mk_alu(8'h11, 1, 1, 22, 23, 0, 0, 0, 64'd4), 0);
        reg_is("R7", 22, 32'h08000000);
        run("R12", mk_alu(8'h10, 1, 1, 22, 1, 0, 0, 0, 64'd33), 0);
        reg_is("R12", 22, 32'd10);
        run("R12", mk_alu(8'h19, 1, 1, 22, 21, 0, 0, 0, 64'd0), 0);
        reg_is("R12", 22, 32'd5);
        run("R12", mk_alu(8'h08, 1, 1, 22, 21, 0, 0, 0, 64'd3), 0);
        reg_is("R12", 22, 32'd3);
        run("R4", mk_mv(1, 1, 0, 24, 0, 64'd17), 0);
        run("R11", mk_alu(8'h1B, 1, 1, 22, 24, 0, 0, 0, 64'd5), 0);
        reg_is("R11", 22, 32'd2);
        run("R11", mk_alu(8'h07, 1, 1, 22, 24, 0, 0, 0, 64'd5), 0);
        reg_is("R11", 22, 32'd3);
    endtask

    task automatic t_faults;
        run("R11", mk_alu(8'h07, 1, 1, 25, 24, 0, 0, 0, 64'd0), 4);
        reg_is("R11", 25, 32'hFFFFFFFF);
        run("R10", mk_alu(8'h1A, 1, 1, 26, 1, 0, 0, 0, 64'd2), 3);
        run("R10", mk_alu(8'h1D, 1, 1, 26, 1, 0, 0, 0, 64'd2), 3);
        run("R10", mk_alu(8'h17, 1, 1, 26, 1, 0, 0, 0, 64'd2), 3);
        reg_is("R10", 26, 32'd0);
        begin
            logic [511:0] b = mk_mv(1, 1, 0, 27, 0, 64'd9);
            b[7:0] = 8'h55;
            run("R3", b, 1);
        end
        reg_is("R3", 27, 32'd0);
    endtask

    task automatic t_alu64;
        run("R9", mk_alu(8'h04, 2, 1, 0, 10, 0, 30, 31, 64'h00000000FFFFFFFF), 0);
        reg_is("R9", 30, 32'h55667787);
        reg_is("R9", 31, 32'h11223345);
        run("R9", mk_alu(8'h05, 2, 0, 0, 10, 30, 32, 33, 64'h0), 0);
        reg_is("R9", 32, 32'h00000001);
        reg_is("R9", 33, 32'hFFFFFFFF);
        run("R6", mk_alu(8'h04, 2, 1, 0, 10, 0, 40, 42, 64'd1), 2);
        reg_is("R6", 40, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        t_reset;
        t_move32;
        t_move64;
        t_alu_basic;
        t_compare;
        t_shift_misc;
        t_faults;
        t_alu64;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule